// File: doc/BRIEF.md
# Periodic Rate Divider

This block turns a 32768 Hz time base into a programmable periodic event. The time base arrives as a one-cycle enable pulse (`base_tick`) in the system clock domain. Each pulse advances a 15-stage binary divider chain, and a four-bit rate code chooses which stage's rising transition counts as an event. An event sets a sticky periodic flag. The flag raises an interrupt line when the periodic enable is set, and it is cleared by software reading the status register.

The rate code does not map linearly to a frequency. Zero turns the event off. Codes 3 to 15 run from 8192 Hz down to 2 Hz, halving the rate at each step. Codes 1 and 2 give the same rates as codes 8 and 9. A three-bit base-select field sits beside the rate code. When it holds 111, the divider chain is kept at zero. Releasing that field later lets the chain restart from a known phase.

Top module: `prd_top`

## Requirements
- R1: After reset, the rate register reads 0x26 (base select 010, rate code 0110), the control register reads 0x00, the periodic flag is 0 and `irq` is 0.
- R2: The registers are addressed by a two-bit select. Select 0 is the rate register: bits 3-0 hold the rate code, bits 6-4 the base select, and bit 7 reads 0. Select 1 is the control register: bit 6 is the periodic enable and the other bits read 0. Select 2 is the status register: bit 6 is the periodic flag and the other bits read 0. Writes to select 2 or 3 change nothing.
- R3: For a rate code n from 3 to 15, an event occurs every 2^(n-1) base ticks. This is 4 ticks for code 3, 32 ticks for code 6 and 16384 ticks for code 15.
- R4: Codes 1 and 2 give periods of 128 and 256 base ticks, the same as codes 8 and 9.
- R5: Rate code 0 produces no events.
- R6: The periodic flag reads 1 from the clock edge after the edge at which an event occurs. It stays at 1 until it is cleared.
- R7: An enabled read of select 2 returns the flag as it stood before the read, then clears the flag at that clock edge. If an event falls on the same edge, the flag stays set.
- R8: `irq` is 1 exactly when the periodic enable and the periodic flag are both 1.
- R9: While the base select is 111, the divider chain is held at zero and no events occur. After release, the first event comes on the 2^(n-2)-th base tick (16 ticks for code 6).
- R10: A change of rate code takes effect at the next rising transition of the newly selected stage. No shortened interval is produced beyond that first one.
- R11: The divider advances only on base ticks. With no base ticks, no events occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| base_tick | input | 1 | One-cycle pulse at the 32768 Hz time-base rate |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe (a read of select 2 clears the flag) |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | 8 | Contents of the register chosen by `rd_sel` |
| periodic_flag | output | 1 | Sticky periodic event flag |
| irq | output | 1 | Periodic interrupt request |

## Verification
The assertions assume that `base_tick` is a pulse in the system clock domain that never stays high for two cycles in a row. They also assume that at most one register access happens per cycle on each strobe. The stimulus drives the tick every second clock and moves every strobe on the falling edge, so both conditions always hold. Rate changes, hold and release, and reads are issued at arbitrary phases of the divider. A behavioural model follows every one of these situations, including a read that lands on an event edge.

// File: rtl/prd_pkg.sv
package prd_pkg;

  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    SEL_RATE = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam logic [2:0] BASE_HOLD    = 3'b111;
  localparam logic [2:0] BASE_DEFAULT = 3'b010;
  localparam logic [3:0] RATE_DEFAULT = 4'b0110;

  localparam int PIE_BIT  = 6;
  localparam int FLAG_BIT = 6;

endpackage

// File: rtl/prd_rate_decode.sv
module prd_rate_decode #(
  parameter int CODE_W     = 4,
  parameter int TAP_W      = 4,
  parameter int FIRST_CODE = 3,
  parameter int FIRST_TAP  = 1,
  parameter int ALIAS_LO   = 1,
  parameter int ALIAS_HI   = 2,
  parameter int ALIAS_OFS  = 7
) (
  input  logic [CODE_W-1:0] rate_code,
  output logic              tap_en,
  output logic [TAP_W-1:0]  tap_idx
);

  localparam int CODE_TO_TAP = FIRST_CODE - FIRST_TAP;

  logic              is_alias;
  logic [CODE_W-1:0] eff_code;

  always_comb begin
    is_alias = (rate_code >= CODE_W'(ALIAS_LO)) && (rate_code <= CODE_W'(ALIAS_HI));
    eff_code = rate_code;
    if (is_alias) begin
      eff_code = rate_code + CODE_W'(ALIAS_OFS);
    end
    tap_en  = is_alias || (rate_code >= CODE_W'(FIRST_CODE));
    tap_idx = TAP_W'(eff_code - CODE_W'(CODE_TO_TAP));
  end

endmodule

// File: rtl/prd_div_chain.sv
module prd_div_chain #(
  parameter int CHAIN_W = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               base_tick,
  input  logic               hold,
  output logic [CHAIN_W-1:0] cnt
);

  logic [CHAIN_W-1:0] cnt_d;
  logic               cnt_en;

  always_comb begin
    cnt_en = base_tick | hold;
    if (hold) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt_en) begin
      cnt <= cnt_d;
    end
  end

  a_r9_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (cnt == '0));

  a_r11_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!base_tick && !hold) |=> $stable(cnt));

  a_r3_tick_step: assert property (@(posedge clk) disable iff (!rst_n)
    (base_tick && !hold) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/prd_tap_detect.sv
module prd_tap_detect #(
  parameter int CHAIN_W = 15,
  parameter int TAP_W   = 4
) (
  input  logic [CHAIN_W-1:0] cnt,
  input  logic               base_tick,
  input  logic               hold,
  input  logic               tap_en,
  input  logic [TAP_W-1:0]   tap_idx,
  output logic               tick_evt
);

  localparam int HIT_N = 1 << TAP_W;

  // hit[i]: the next increment lifts stage i from 0 to 1
  logic [HIT_N-1:0] hit;

  genvar i;
  for (i = 0; i < HIT_N; i++) begin : g_hit
    if (i == 0) begin : g_first
      assign hit[i] = ~cnt[0];
    end else if (i < CHAIN_W) begin : g_stage
      assign hit[i] = (&cnt[i-1:0]) & ~cnt[i];
    end else begin : g_unused
      assign hit[i] = 1'b0;
    end
  end

  assign tick_evt = base_tick & ~hold & tap_en & hit[tap_idx];

endmodule

// File: rtl/prd_regs.sv
module prd_regs
  import prd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_en,
  input  logic [1:0]       rd_sel,
  input  logic             tick_evt,
  output logic [3:0]       rate_code,
  output logic [2:0]       base_sel,
  output logic             pie,
  output logic             flag,
  output logic [REG_W-1:0] rd_data
);

  logic [3:0] code_d;
  logic [2:0] base_d;
  logic       pie_d;
  logic       flag_d;
  logic       wr_rate;
  logic       wr_ctrl;
  logic       rd_clear;

  always_comb begin
    wr_rate  = wr_en && (reg_sel_e'(wr_sel) == SEL_RATE);
    wr_ctrl  = wr_en && (reg_sel_e'(wr_sel) == SEL_CTRL);
    rd_clear = rd_en && (reg_sel_e'(rd_sel) == SEL_STAT);

    code_d = rate_code;
    base_d = base_sel;
    if (wr_rate) begin
      code_d = wr_data[3:0];
      base_d = wr_data[6:4];
    end

    pie_d = pie;
    if (wr_ctrl) begin
      pie_d = wr_data[PIE_BIT];
    end

    flag_d = flag;
    if (tick_evt) begin
      flag_d = 1'b1;
    end else if (rd_clear) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_code <= RATE_DEFAULT;
      base_sel  <= BASE_DEFAULT;
      pie       <= 1'b0;
      flag      <= 1'b0;
    end else begin
      if (wr_rate) begin
        rate_code <= code_d;
        base_sel  <= base_d;
      end
      if (wr_ctrl) begin
        pie <= pie_d;
      end
      flag <= flag_d;
    end
  end

  always_comb begin
    rd_data = '0;
    unique case (reg_sel_e'(rd_sel))
      SEL_RATE: rd_data = {1'b0, base_sel, rate_code};
      SEL_CTRL: rd_data[PIE_BIT] = pie;
      SEL_STAT: rd_data[FLAG_BIT] = flag;
      default:  rd_data = '0;
    endcase
  end

  a_r6_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    tick_evt |=> flag);

  a_r6_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(tick_evt));

  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clear && !tick_evt) |=> !flag);

  a_r2_stat_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_sel[1] == 1'b1)) |=> ($stable(rate_code) && $stable(base_sel) && $stable(pie)));

endmodule

// File: rtl/prd_top.sv
module prd_top
  import prd_pkg::*;
#(
  parameter int CHAIN_W = 15,
  parameter int CODE_W  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       base_tick,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  input  logic [1:0] rd_sel,
  output logic [7:0] rd_data,
  output logic       periodic_flag,
  output logic       irq
);

  localparam int TAP_W = $clog2(CHAIN_W);

  logic               rst_meta;
  logic               rst_q;
  logic [CHAIN_W-1:0] cnt;
  logic [3:0]         rate_code;
  logic [2:0]         base_sel;
  logic               pie;
  logic               flag;
  logic               hold;
  logic               tap_en;
  logic [TAP_W-1:0]   tap_idx;
  logic               tick_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  assign hold = (base_sel == BASE_HOLD);

  prd_rate_decode #(
    .CODE_W (CODE_W),
    .TAP_W  (TAP_W)
  ) u_decode (
    .rate_code (rate_code),
    .tap_en    (tap_en),
    .tap_idx   (tap_idx)
  );

  prd_div_chain #(
    .CHAIN_W (CHAIN_W)
  ) u_chain (
    .clk       (clk),
    .rst_n     (rst_q),
    .base_tick (base_tick),
    .hold      (hold),
    .cnt       (cnt)
  );

  prd_tap_detect #(
    .CHAIN_W (CHAIN_W),
    .TAP_W   (TAP_W)
  ) u_tap (
    .cnt       (cnt),
    .base_tick (base_tick),
    .hold      (hold),
    .tap_en    (tap_en),
    .tap_idx   (tap_idx),
    .tick_evt  (tick_evt)
  );

  prd_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_q),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .rd_en     (rd_en),
    .rd_sel    (rd_sel),
    .tick_evt  (tick_evt),
    .rate_code (rate_code),
    .base_sel  (base_sel),
    .pie       (pie),
    .flag      (flag),
    .rd_data   (rd_data)
  );

  assign periodic_flag = flag;
  assign irq           = flag & pie;

  a_r5_code_off: assert property (@(posedge clk) disable iff (!rst_q)
    (rate_code == 4'd0) |-> !tick_evt);

  a_r11_event_on_tick: assert property (@(posedge clk) disable iff (!rst_q)
    tick_evt |-> base_tick);

  a_r9_no_event_held: assert property (@(posedge clk) disable iff (!rst_q)
    (base_sel == BASE_HOLD) |-> !tick_evt);

endmodule

// File: tb/prd_top_test.sv
module prd_top_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       base_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       rd_en = 1'b0;
  logic [1:0] rd_sel = 2'd0;
  logic [7:0] rd_data;
  logic       periodic_flag;
  logic       irq;

  int    checks = 0;
  int    errors = 0;
  bit    run = 1'b0;
  bit    tick_on = 1'b0;
  bit    done = 1'b0;
  string cur_tag = "R6";

  // behavioural reference state
  int m_rate = 8'h26;
  int m_ctrl = 0;
  int m_flag = 0;
  int m_cnt  = 0;
  int tick_total = 0;

  always #10 clk = ~clk;

  prd_top uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .base_tick     (base_tick),
    .wr_en         (wr_en),
    .wr_sel        (wr_sel),
    .wr_data       (wr_data),
    .rd_en         (rd_en),
    .rd_sel        (rd_sel),
    .rd_data       (rd_data),
    .periodic_flag (periodic_flag),
    .irq           (irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int tap_of(input int code);
    int c;
    c = code;
    if (c == 0) return -1;
    if (c < 3) c = c + 7;
    return c - 2;
  endfunction

  function automatic int exp_rd(input int sel);
    case (sel)
      0: return m_rate;
      1: return m_ctrl;
      2: return m_flag << 6;
      default: return 0;
    endcase
  endfunction

  always @(negedge clk) begin
    if (tick_on) base_tick <= ~base_tick;
    else base_tick <= 1'b0;
  end

  always @(posedge clk) begin
    if (base_tick) tick_total = tick_total + 1;
    if (run) begin
      int k;
      bit ev;
      ev = 1'b0;
      k = tap_of(m_rate & 15);
      if (((m_rate >> 4) & 7) == 7) begin
        m_cnt = 0;
      end else if (base_tick) begin
        if (k >= 0 && (m_cnt % (2 << k)) == ((1 << k) - 1)) ev = 1'b1;
        m_cnt = (m_cnt + 1) % 32768;
      end
      if (ev) m_flag = 1;
      else if (rd_en && rd_sel == 2'd2) m_flag = 0;
      if (wr_en && wr_sel == 2'd0) m_rate = wr_data & 8'h7F;
      if (wr_en && wr_sel == 2'd1) m_ctrl = wr_data & 8'h40;
    end
  end

  always begin
    @(posedge clk);
    #5;
    if (run && !done) begin
      chk(cur_tag, periodic_flag, m_flag);
      chk("R8", irq, m_flag & ((m_ctrl >> 6) & 1));
      chk("R2", rd_data, exp_rd(rd_sel));
    end
  end

  task automatic wr(input int sel, input int data);
    @(negedge clk);
    wr_en = 1'b1;
    wr_sel = 2'(sel);
    wr_data = 8'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int sel, output int val);
    @(negedge clk);
    rd_en = 1'b1;
    rd_sel = 2'(sel);
    #5;
    val = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
    rd_sel = 2'd0;
  endtask

  task automatic wait_flag();
    while (!periodic_flag) @(negedge clk);
  endtask

  task automatic period(input string tag, input int expected);
    int t1;
    int v;
    wait_flag();
    t1 = tick_total;
    rd(2, v);
    wait_flag();
    chk(tag, tick_total - t1, expected);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int v;
    int t0;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1", periodic_flag, 0);
    chk("R1", irq, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    rd(0, v); chk("R1", v, 8'h26);
    rd(1, v); chk("R1", v, 0);
    rd(2, v); chk("R1", v, 0);
    run = 1'b1;
    tick_on = 1'b1;

    // R3: default code 6, 32 ticks
    cur_tag = "R3";
    period("R3", 32);

    // R8: enable interrupt while flag pending
    rd(2, v);
    wait_flag();
    chk("R8", irq, 0);
    wr(1, 8'hFF);
    chk("R8", irq, 1);
    rd(1, v); chk("R2", v, 8'h40);
    rd(2, v); chk("R7", v, 8'h40);
    chk("R7", periodic_flag, 0);
    chk("R8", irq, 0);
    wr(1, 0);

    // R2: register bit masks and ignored writes
    cur_tag = "R2";
    wr(0, 8'hFF);
    rd(0, v); chk("R2", v, 8'h7F);
    rd(2, v);
    wr(2, 8'hFF);
    wr(3, 8'hFF);
    rd(0, v); chk("R2", v, 8'h7F);
    rd(1, v); chk("R2", v, 0);
    chk("R2", periodic_flag, 0);

    // R9: hold then release with code 6
    cur_tag = "R9";
    wr(0, 8'h76);
    rd(2, v);
    repeat (600) @(negedge clk);
    chk("R9", periodic_flag, 0);
    wr(0, 8'h26);
    t0 = tick_total;
    wait_flag();
    chk("R9", tick_total - t0, 16);

    // R3: fastest code
    cur_tag = "R3";
    wr(0, 8'h23);
    rd(2, v);
    period("R3", 4);

    // R7: back-to-back status reads against events
    cur_tag = "R7";
    @(negedge clk);
    rd_en = 1'b1;
    rd_sel = 2'd2;
    repeat (60) @(negedge clk);
    rd_en = 1'b0;
    rd_sel = 2'd0;

    // R4: aliased codes
    cur_tag = "R4";
    wr(0, 8'h21);
    rd(2, v);
    period("R4", 128);
    wr(0, 8'h22);
    rd(2, v);
    period("R4", 256);
    wr(0, 8'h28);
    rd(2, v);
    period("R4", 128);

    // R5: code 0
    cur_tag = "R5";
    wr(0, 8'h20);
    rd(2, v);
    repeat (1200) @(negedge clk);
    chk("R5", periodic_flag, 0);

    // R11: no base ticks
    cur_tag = "R11";
    wr(0, 8'h23);
    tick_on = 1'b0;
    @(negedge clk);
    rd(2, v);
    repeat (200) @(negedge clk);
    chk("R11", periodic_flag, 0);
    tick_on = 1'b1;

    // R10: switch from slow to fast mid-count
    cur_tag = "R10";
    wr(0, 8'h2F);
    repeat (301) @(negedge clk);
    wr(0, 8'h23);
    rd(2, v);
    t0 = tick_total;
    wait_flag();
    chk("R10", (tick_total - t0) <= 4, 1);
    period("R10", 4);
    wr(0, 8'h26);
    rd(2, v);
    period("R10", 32);

    // R3: slowest code
    cur_tag = "R3";
    wr(0, 8'h2F);
    rd(2, v);
    period("R3", 16384);

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule